// File: doc/BRIEF.md
# Page Table Walk Step Unit

This block carries out a single step of a page table walk that software drives one level at a time. It has two operations. A directory step takes a table pointer or entry, a level number and the faulting virtual address. It returns one of three things: the pointer to the next level, fetched over a simple memory read port; a huge-page entry marked with the level at which it was found; or the input unchanged when the level is not valid. A leaf step takes a table pointer or a marked huge-page entry and produces the even or odd TLB entry value together with the page size.

The per-level shift and width fields and the entry-size field arrive as inputs, so the block holds no configuration. The block takes one operation at a time. A controller with four states sequences it. In IDLE the block accepts a request. It moves to MEM_REQ when the operation needs a table read, and to FINISH when it does not. MEM_REQ goes to MEM_WAIT once the read request is accepted. MEM_WAIT goes to FINISH when the response arrives. FINISH pulses `done` with the result and returns to IDLE.

Top module: `pwstep_unit`

## Requirements
- R1: After reset, `req_ready` is 1 and `done`, `mem_req_valid` and `huge_l4` are 0.
- R2: A directory step (`req_leaf`=0) whose level is 0 or greater than 4 returns `req_base` unchanged with `page_size` 0. It issues no memory read, and `done` is high in the cycle after the request is accepted.
- R3: A directory step whose base has bit 6 set is a huge-page entry and issues no memory read. If the 2-bit tag at bits 14:13 is non-zero, the base is returned unchanged. If the tag is zero, the level's two low bits are written into bits 14:13. `done` follows one cycle after acceptance.
- R4: A huge-page entry seen by a directory step at level 4 is still processed as in R3, and `huge_l4` is high together with `done`.
- R5: A non-huge directory step at a valid level N reads address (base masked to PA_W bits) OR (index << shift). Here index = (vaddr >> shift field N) & ((1 << width field N) - 1), and shift = (`cfg_pte_w` + 1) * 3. Field slot k occupies bits [6k+5:6k] of `cfg_base` and `cfg_width`; slot 0 is the leaf table and slots 1 to 4 are the levels.
- R6: The result of a memory-backed step is the response data with every bit at PA_W and above cleared. `done` is high in the cycle after the response is taken.
- R7: `mem_req_valid` and `mem_req_addr` stay steady until `mem_req_ready` is seen, and each operation issues at most one read.
- R8: A leaf step on a table pointer (bit 6 of the masked base clear) reads at base | (even_index << shift) for the even half and at base | ((even_index + 1) << shift) for the odd half (`req_odd`=1). Here even_index is the slot 0 index with bit 0 cleared. `page_size` is the slot 0 shift field.
- R9: A leaf step on a huge entry first masks the base to PA_W bits. It then clears bits 14:13 and bit 6; if bit 12 was set, it clears bit 12 and sets bit 6. No memory read occurs.
- R10: For a huge leaf step, `page_size` = shift + width − 1 of the slot named by the tag. For the odd half, the entry value has 1 << `page_size` added.
- R11: While an operation is in progress (`mem_req_valid` high, or waiting for a response), `req_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Operation request |
| req_ready | output | 1 | Block idle and able to accept |
| req_leaf | input | 1 | 1 = leaf step, 0 = directory step |
| req_base | input | DATA_W | Table pointer or entry |
| req_level | input | 3 | Directory level |
| req_odd | input | 1 | Leaf step selects the odd half |
| req_vaddr | input | DATA_W | Faulting virtual address |
| cfg_base | input | 5*SH_W | Per-slot shift fields |
| cfg_width | input | 5*SH_W | Per-slot width fields |
| cfg_pte_w | input | 2 | Entry size code |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Read request accepted |
| mem_req_addr | output | DATA_W | Read address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | DATA_W | Read data |
| done | output | 1 | One-cycle result strobe |
| result | output | DATA_W | Step result |
| page_size | output | SH_W | Page size exponent (leaf steps) |
| huge_l4 | output | 1 | Huge entry seen at level 4 |

## Verification
A controller stuck outside IDLE shows within a cycle as `req_ready` staying low, and the next operation then never starts. A wrong level decode or a wrong huge-flag test shows in one of two ways. If it wrongly chooses a memory read, a read request appears where `done` was due one cycle after acceptance. If it wrongly skips the read, `done` appears with no read. A fault in index, mask or bit rewriting appears at once as a wrong `mem_req_addr` or a wrong `result`/`page_size` at the `done` strobe. The bench compares each of these against queued expectations on every operation.

// File: rtl/pwstep_pkg.sv
package pwstep_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_MEM_REQ,
        ST_MEM_WAIT,
        ST_FINISH
    } pw_state_e;

    localparam int HUGE_BIT = 6;
    localparam int HGLB_BIT = 12;
    localparam int TAG_LO   = 13;
    localparam int TAG_W    = 2;
endpackage

// File: rtl/pwstep_field_sel.sv
module pwstep_field_sel #(
    parameter int SH_W   = 6,
    parameter int SLOTS  = 5,
    parameter int SLOT_W = 3
) (
    input  logic [SLOTS*SH_W-1:0] base_flat_i,
    input  logic [SLOTS*SH_W-1:0] width_flat_i,
    input  logic [SLOT_W-1:0]     slot_i,
    output logic [SH_W-1:0]       sel_base_o,
    output logic [SH_W-1:0]       sel_width_o
);
    logic [SH_W-1:0] base_arr  [SLOTS];
    logic [SH_W-1:0] width_arr [SLOTS];

    for (genvar g = 0; g < SLOTS; g++) begin : g_unpack
        assign base_arr[g]  = base_flat_i[g*SH_W +: SH_W];
        assign width_arr[g] = width_flat_i[g*SH_W +: SH_W];
    end

    always_comb begin
        sel_base_o  = '0;
        sel_width_o = '0;
        for (int k = 0; k < SLOTS; k++) begin
            if (slot_i == SLOT_W'(k)) begin
                sel_base_o  = base_arr[k];
                sel_width_o = width_arr[k];
            end
        end
    end
endmodule

// File: rtl/pwstep_dir.sv
module pwstep_dir
    import pwstep_pkg::*;
#(
    parameter int DATA_W  = 64,
    parameter int PA_W    = 48,
    parameter int SH_W    = 6,
    parameter int LVL_W   = 3,
    parameter int MAX_LVL = 4
) (
    input  logic [DATA_W-1:0] base_i,
    input  logic [DATA_W-1:0] vaddr_i,
    input  logic [LVL_W-1:0]  level_i,
    input  logic [SH_W-1:0]   fbase_i,
    input  logic [SH_W-1:0]   fwidth_i,
    input  logic [SH_W-1:0]   shift_i,
    output logic              need_mem_o,
    output logic [DATA_W-1:0] addr_o,
    output logic [DATA_W-1:0] result_o,
    output logic              l4_o
);
    localparam logic [DATA_W-1:0] PA_MASK = {{(DATA_W-PA_W){1'b0}}, {PA_W{1'b1}}};
    localparam logic [DATA_W-1:0] ONE     = DATA_W'(1);

    logic              lvl_ok;
    logic              huge;
    logic [TAG_W-1:0]  tag;
    logic [DATA_W-1:0] index;

    assign lvl_ok = (level_i != '0) && (level_i <= LVL_W'(MAX_LVL));
    assign huge   = base_i[HUGE_BIT];
    assign tag    = base_i[TAG_LO +: TAG_W];
    assign index  = (vaddr_i >> fbase_i) & ((ONE << fwidth_i) - ONE);
    assign addr_o = (base_i & PA_MASK) | (index << shift_i);

    always_comb begin
        result_o   = base_i;
        need_mem_o = 1'b0;
        l4_o       = 1'b0;
        if (lvl_ok) begin
            if (huge) begin
                l4_o = (level_i == LVL_W'(MAX_LVL));
                if (tag == '0) begin
                    result_o[TAG_LO +: TAG_W] = level_i[TAG_W-1:0];
                end
            end else begin
                need_mem_o = 1'b1;
            end
        end
    end
endmodule

// File: rtl/pwstep_leaf.sv
module pwstep_leaf
    import pwstep_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int PA_W   = 48,
    parameter int SH_W   = 6
) (
    input  logic [DATA_W-1:0] base_i,
    input  logic [DATA_W-1:0] vaddr_i,
    input  logic              odd_i,
    input  logic [SH_W-1:0]   hbase_i,
    input  logic [SH_W-1:0]   hwidth_i,
    input  logic [SH_W-1:0]   ptbase_i,
    input  logic [SH_W-1:0]   ptwidth_i,
    input  logic [SH_W-1:0]   shift_i,
    output logic              need_mem_o,
    output logic [DATA_W-1:0] addr_o,
    output logic [DATA_W-1:0] result_o,
    output logic [SH_W-1:0]   psize_o
);
    localparam logic [DATA_W-1:0] PA_MASK = {{(DATA_W-PA_W){1'b0}}, {PA_W{1'b1}}};
    localparam logic [DATA_W-1:0] ONE     = DATA_W'(1);

    logic [DATA_W-1:0] mb;
    logic [DATA_W-1:0] pt_idx;
    logic [DATA_W-1:0] entry;
    logic [SH_W-1:0]   huge_ps;

    assign mb      = base_i & PA_MASK;
    assign pt_idx  = ((vaddr_i >> ptbase_i) & ((ONE << ptwidth_i) - ONE)) & ~ONE;
    assign addr_o  = mb | ((pt_idx + (odd_i ? ONE : '0)) << shift_i);
    assign huge_ps = hbase_i + hwidth_i - SH_W'(1);

    always_comb begin
        entry                    = mb;
        entry[TAG_LO +: TAG_W]   = '0;
        entry[HUGE_BIT]          = 1'b0;
        if (mb[HGLB_BIT]) begin
            entry[HGLB_BIT] = 1'b0;
            entry[HUGE_BIT] = 1'b1;
        end
        if (odd_i) begin
            entry = entry + (ONE << huge_ps);
        end
    end

    always_comb begin
        if (mb[HUGE_BIT]) begin
            need_mem_o = 1'b0;
            result_o   = entry;
            psize_o    = huge_ps;
        end else begin
            need_mem_o = 1'b1;
            result_o   = '0;
            psize_o    = ptbase_i;
        end
    end
endmodule

// File: rtl/pwstep_unit.sv
module pwstep_unit
    import pwstep_pkg::*;
#(
    parameter int DATA_W  = 64,
    parameter int PA_W    = 48,
    parameter int SH_W    = 6,
    parameter int LVL_W   = 3,
    parameter int MAX_LVL = 4,
    parameter int PTE_W_W = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_valid,
    output logic                          req_ready,
    input  logic                          req_leaf,
    input  logic [DATA_W-1:0]             req_base,
    input  logic [LVL_W-1:0]              req_level,
    input  logic                          req_odd,
    input  logic [DATA_W-1:0]             req_vaddr,
    input  logic [(MAX_LVL+1)*SH_W-1:0]   cfg_base,
    input  logic [(MAX_LVL+1)*SH_W-1:0]   cfg_width,
    input  logic [PTE_W_W-1:0]            cfg_pte_w,
    output logic                          mem_req_valid,
    input  logic                          mem_req_ready,
    output logic [DATA_W-1:0]             mem_req_addr,
    input  logic                          mem_rsp_valid,
    input  logic [DATA_W-1:0]             mem_rsp_data,
    output logic                          done,
    output logic [DATA_W-1:0]             result,
    output logic [SH_W-1:0]               page_size,
    output logic                          huge_l4
);
    localparam int SLOTS = MAX_LVL + 1;
    localparam logic [DATA_W-1:0] PA_MASK = {{(DATA_W-PA_W){1'b0}}, {PA_W{1'b1}}};

    pw_state_e state_q, state_d;

    logic [SH_W-1:0]   shift;
    logic [LVL_W-1:0]  slot;
    logic [SH_W-1:0]   f_base, f_width;
    logic [DATA_W-1:0] masked_base;

    logic              d_mem, d_l4;
    logic [DATA_W-1:0] d_addr, d_res;
    logic              l_mem;
    logic [DATA_W-1:0] l_addr, l_res;
    logic [SH_W-1:0]   l_ps;

    logic              op_mem;
    logic              accept;

    logic [DATA_W-1:0] res_q, addr_q;
    logic [SH_W-1:0]   ps_q;
    logic              l4_q;

    assign shift       = (SH_W'(cfg_pte_w) + SH_W'(1)) * SH_W'(3);
    assign masked_base = req_base & PA_MASK;
    assign slot        = req_leaf ? LVL_W'(masked_base[TAG_LO +: TAG_W]) : req_level;

    pwstep_field_sel #(.SH_W(SH_W), .SLOTS(SLOTS), .SLOT_W(LVL_W)) u_sel (
        .base_flat_i (cfg_base),
        .width_flat_i(cfg_width),
        .slot_i      (slot),
        .sel_base_o  (f_base),
        .sel_width_o (f_width)
    );

    pwstep_dir #(.DATA_W(DATA_W), .PA_W(PA_W), .SH_W(SH_W), .LVL_W(LVL_W),
                 .MAX_LVL(MAX_LVL)) u_dir (
        .base_i    (req_base),
        .vaddr_i   (req_vaddr),
        .level_i   (req_level),
        .fbase_i   (f_base),
        .fwidth_i  (f_width),
        .shift_i   (shift),
        .need_mem_o(d_mem),
        .addr_o    (d_addr),
        .result_o  (d_res),
        .l4_o      (d_l4)
    );

    pwstep_leaf #(.DATA_W(DATA_W), .PA_W(PA_W), .SH_W(SH_W)) u_leaf (
        .base_i    (req_base),
        .vaddr_i   (req_vaddr),
        .odd_i     (req_odd),
        .hbase_i   (f_base),
        .hwidth_i  (f_width),
        .ptbase_i  (cfg_base[SH_W-1:0]),
        .ptwidth_i (cfg_width[SH_W-1:0]),
        .shift_i   (shift),
        .need_mem_o(l_mem),
        .addr_o    (l_addr),
        .result_o  (l_res),
        .psize_o   (l_ps)
    );

    assign accept = req_valid && (state_q == ST_IDLE);
    assign op_mem = req_leaf ? l_mem : d_mem;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (req_valid) state_d = op_mem ? ST_MEM_REQ : ST_FINISH;
            ST_MEM_REQ:  if (mem_req_ready) state_d = ST_MEM_WAIT;
            ST_MEM_WAIT: if (mem_rsp_valid) state_d = ST_FINISH;
            ST_FINISH:   state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q  <= '0;
            addr_q <= '0;
            ps_q   <= '0;
            l4_q   <= 1'b0;
        end else begin
            if (accept) begin
                addr_q <= req_leaf ? l_addr : d_addr;
                res_q  <= req_leaf ? l_res : d_res;
                ps_q   <= req_leaf ? l_ps : '0;
                l4_q   <= !req_leaf && d_l4;
            end else if (state_q == ST_MEM_WAIT && mem_rsp_valid) begin
                res_q <= mem_rsp_data & PA_MASK;
            end
        end
    end

    always_comb begin
        req_ready     = (state_q == ST_IDLE);
        mem_req_valid = (state_q == ST_MEM_REQ);
        mem_req_addr  = addr_q;
        done          = (state_q == ST_FINISH);
        result        = res_q;
        page_size     = ps_q;
        huge_l4       = done && l4_q;
    end

    AST_BAD_LEVEL_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !req_leaf && (req_level == '0 || req_level > LVL_W'(MAX_LVL))) |=> done); // R2
    AST_HUGE_DIR_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !req_leaf && req_base[HUGE_BIT]) |=> (done && !mem_req_valid)); // R3
    AST_L4_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        huge_l4 |-> done); // R4
    AST_DONE_AFTER_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rsp_valid && state_q == ST_MEM_WAIT) |=> (done && result[DATA_W-1:PA_W] == '0)); // R6
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R7
    AST_SINGLE_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_ready) |=> !mem_req_valid); // R7
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid || state_q == ST_MEM_WAIT) |-> !req_ready); // R11
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R6
endmodule

// File: tb/pwstep_unit_tb.sv
module pwstep_unit_tb;
    localparam int DW = 64;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0;
    logic            req_ready;
    logic            req_leaf = 1'b0;
    logic [DW-1:0]   req_base = '0;
    logic [2:0]      req_level = '0;
    logic            req_odd = 1'b0;
    logic [DW-1:0]   req_vaddr = '0;
    logic [29:0]     cfg_base;
    logic [29:0]     cfg_width;
    logic [1:0]      cfg_pte_w = 2'd0;
    logic            mem_req_valid;
    logic            mem_req_ready = 1'b0;
    logic [DW-1:0]   mem_req_addr;
    logic            mem_rsp_valid = 1'b0;
    logic [DW-1:0]   mem_rsp_data = '0;
    logic            done;
    logic [DW-1:0]   result;
    logic [5:0]      page_size;
    logic            huge_l4;

    // slot k: shift 12+9k, width 9
    assign cfg_base  = {6'd48, 6'd39, 6'd30, 6'd21, 6'd12};
    assign cfg_width = {6'd9, 6'd9, 6'd9, 6'd9, 6'd9};

    always #4 clk = ~clk;

    pwstep_unit u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_leaf(req_leaf), .req_base(req_base), .req_level(req_level),
        .req_odd(req_odd), .req_vaddr(req_vaddr), .cfg_base(cfg_base),
        .cfg_width(cfg_width), .cfg_pte_w(cfg_pte_w), .mem_req_valid(mem_req_valid),
        .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data), .done(done),
        .result(result), .page_size(page_size), .huge_l4(huge_l4)
    );

    typedef struct {
        logic [DW-1:0] res;
        logic [5:0]    ps;
        logic          flag;
        string         rq;
    } exp_t;

    typedef struct {
        logic [DW-1:0] addr;
        string         rq;
    } addr_t;

    exp_t  exp_q[$];
    addr_t addr_q[$];
    int    checks = 0;
    int    errors = 0;
    int    stall_sel = 0;
    bit    finished = 1'b0;

    localparam logic [DW-1:0] V = 64'h0000_5A5A_C3C3_1F28;

    function automatic logic [DW-1:0] mem_word(input logic [DW-1:0] a);
        return {16'hBEEF, a[47:0] ^ 48'h0000_0ABC_D000};
    endfunction

    function automatic logic [DW-1:0] idx(input logic [DW-1:0] v, input int sh, input int w);
        return (v >> sh) & ((64'd1 << w) - 64'd1);
    endfunction

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", rq, what, act, expv);
        end
    endtask

    task automatic do_op(input bit leaf, input logic [DW-1:0] base, input logic [2:0] lvl,
                         input bit odd, input bit mem, input logic [DW-1:0] eaddr,
                         input logic [DW-1:0] eres, input logic [5:0] eps,
                         input bit eflag, input string rq);
        exp_t e;
        addr_t a;
        e.res  = mem ? (mem_word(eaddr) & 64'h0000_FFFF_FFFF_FFFF) : eres;
        e.ps   = eps;
        e.flag = eflag;
        e.rq   = rq;
        exp_q.push_back(e);
        if (mem) begin
            a.addr = eaddr;
            a.rq   = rq;
            addr_q.push_back(a);
        end
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_leaf  = leaf;
        req_base  = base;
        req_level = lvl;
        req_odd   = odd;
        req_vaddr = V;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        if (!mem) chk(done === 1'b1, rq, "done one cycle after accept", DW'(done), 64'd1);
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    // monitor
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && done) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R6", "unexpected done", 64'd1, 64'd0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(result === e.res, e.rq, "result", result, e.res);
                    chk(page_size === e.ps, e.rq, "page_size", DW'(page_size), DW'(e.ps));
                    chk(huge_l4 === e.flag, e.rq, "huge_l4", DW'(huge_l4), DW'(e.flag));
                end
            end
        end
    end

    // memory model
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && mem_req_valid) begin
                addr_t a;
                logic [DW-1:0] got;
                got = mem_req_addr;
                chk(req_ready === 1'b0, "R11", "ready low while busy", DW'(req_ready), 64'd0);
                if (addr_q.size() == 0) begin
                    chk(1'b0, "R7", "unexpected read", got, 64'd0);
                end else begin
                    a = addr_q.pop_front();
                    chk(got === a.addr, a.rq, "read address", got, a.addr);
                end
                for (int s = 0; s < stall_sel % 3; s++) begin
                    @(negedge clk);
                    chk(mem_req_valid === 1'b1 && mem_req_addr === got, "R7",
                        "request held in stall", mem_req_addr, got);
                end
                stall_sel++;
                mem_req_ready = 1'b1;
                @(negedge clk);
                mem_req_ready = 1'b0;
                chk(mem_req_valid === 1'b0, "R7", "single read", DW'(mem_req_valid), 64'd0);
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = mem_word(got);
                @(negedge clk);
                mem_rsp_valid = 1'b0;
                chk(done === 1'b1, "R6", "done one cycle after response", DW'(done), 64'd1);
            end
        end
    end

    // watchdog
    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] b;
        logic [DW-1:0] ev;
        repeat (3) @(negedge clk);
        chk(req_ready === 1'b1 && done === 1'b0 && mem_req_valid === 1'b0 && huge_l4 === 1'b0,
            "R1", "reset state", {60'd0, req_ready, done, mem_req_valid, huge_l4}, 64'h8);
        rst_n = 1'b1;
        @(negedge clk);

        // R5: non-huge directory steps; base bits above PA dropped
        b = 64'hFF00_0000_0020_0000;
        do_op(1'b0, b, 3'd1, 1'b0, 1'b1, 64'h0020_0000 | (idx(V, 21, 9) << 3), '0, 6'd0, 1'b0, "R5");
        b = 64'h0000_0000_0040_0000;
        do_op(1'b0, b, 3'd3, 1'b0, 1'b1, b | (idx(V, 39, 9) << 3), '0, 6'd0, 1'b0, "R5");
        b = 64'h0000_0000_0080_0000;
        do_op(1'b0, b, 3'd4, 1'b0, 1'b1, b | (idx(V, 48, 9) << 3), '0, 6'd0, 1'b0, "R5");

        // R2: invalid levels
        b = 64'hABCD_0000_1234_5678;
        do_op(1'b0, b, 3'd0, 1'b0, 1'b0, '0, b, 6'd0, 1'b0, "R2");
        do_op(1'b0, b, 3'd5, 1'b0, 1'b0, '0, b, 6'd0, 1'b0, "R2");
        do_op(1'b0, b, 3'd7, 1'b0, 1'b0, '0, b, 6'd0, 1'b0, "R2");

        // R3: huge entries in directory steps
        b = 64'h0000_0001_0000_1040;
        do_op(1'b0, b, 3'd2, 1'b0, 1'b0, '0, 64'h0000_0001_0000_5040, 6'd0, 1'b0, "R3");
        b = 64'h0000_0000_0000_2040;
        do_op(1'b0, b, 3'd3, 1'b0, 1'b0, '0, b, 6'd0, 1'b0, "R3");

        // R4: huge at level 4 (tag field takes the low two level bits)
        b = 64'h0000_0000_0300_0040;
        do_op(1'b0, b, 3'd4, 1'b0, 1'b0, '0, b, 6'd0, 1'b1, "R4");
        b = 64'h0000_0000_0300_6040;
        do_op(1'b0, b, 3'd4, 1'b0, 1'b0, '0, b, 6'd0, 1'b1, "R4");

        // R8: leaf step on a table pointer, even and odd halves
        b = 64'h0000_0000_0030_0000;
        ev = idx(V, 12, 9) & ~64'd1;
        do_op(1'b1, b, 3'd0, 1'b0, 1'b1, b | (ev << 3), '0, 6'd12, 1'b0, "R8");
        do_op(1'b1, b, 3'd0, 1'b1, 1'b1, b | ((ev + 64'd1) << 3), '0, 6'd12, 1'b0, "R8");
        cfg_pte_w = 2'd1;
        do_op(1'b1, b, 3'd0, 1'b1, 1'b1, b | ((ev + 64'd1) << 6), '0, 6'd12, 1'b0, "R8");
        cfg_pte_w = 2'd0;

        // R9/R10: huge page found at level 2, global moved, both halves
        b = 64'h0000_0001_0000_5040;
        do_op(1'b1, b, 3'd0, 1'b0, 1'b0, '0, 64'h0000_0001_0000_0040, 6'd38, 1'b0, "R9");
        do_op(1'b1, b, 3'd0, 1'b1, 1'b0, '0, 64'h0000_0041_0000_0040, 6'd38, 1'b0, "R10");

        // R9: no huge-global, bits above PA masked; R10 size from level-1 tag
        b = 64'hFFFF_0000_8000_2040;
        do_op(1'b1, b, 3'd0, 1'b0, 1'b0, '0, 64'h0000_0000_8000_0000, 6'd29, 1'b0, "R9");
        do_op(1'b1, b, 3'd0, 1'b1, 1'b0, '0, 64'h0000_0000_A000_0000, 6'd29, 1'b0, "R10");

        // R10: tag zero uses the leaf-table slot
        b = 64'h0000_0000_0040_0040;
        do_op(1'b1, b, 3'd0, 1'b1, 1'b0, '0, 64'h0000_0000_0050_0000, 6'd20, 1'b0, "R10");

        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0 && addr_q.size() == 0, "R7", "all expectations consumed",
            DW'(exp_q.size() + addr_q.size()), 64'd0);
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule